// File: doc/BRIEF.md
# Shared Array Write Coordinator

This block owns a two-dimensional array of data words that several independent thread state machines all need to update. No thread writes the storage directly. Each thread raises a request and presents a data word together with a row index and a column index. The coordinator serves one request at a time. It stores the chosen thread's word into the addressed element and returns a one-cycle acknowledge to that thread. Because every element has a single writer, the coordinator, no storage bit ever has more than one source.

The coordinator alternates between two states. In the scan state it picks the lowest-numbered eligible requester, performs that thread's write at the same clock edge and enters a one-cycle wait state. In the wait state the acknowledge is visible to the thread, and the coordinator then returns to scanning. A thread that has been served cannot win again until it has lowered its request, which completes the four-phase handshake. Other threads are not held up by a thread that is slow to release.

A combinational read port returns the element at any row and column. Requests whose indices fall outside the array are acknowledged but write nothing. The array dimensions, the thread count and the word width are parameters.

Top module: `sharedWriteCoord`

## Requirements
- R1: While `rst` is high at a clock edge, every element is cleared to zero, the coordinator enters the scan state and all acknowledge bits are low after that edge.
- R2: When the coordinator is scanning and thread t wins at a clock edge, the element at row `rowFlat[t*ROW_W +: ROW_W]` and column `colFlat[t*COL_W +: COL_W]` takes the value `dataFlat[t*DATA_W +: DATA_W]` at that edge, and `ackVec[t]` is high in the following cycle.
- R3: At most one bit of `ackVec` is high in any cycle, and at most one element is written per clock edge.
- R4: Among threads eligible at the same edge, the lowest thread number wins.
- R5: An acknowledge lasts exactly one cycle. At the edge that ends it the coordinator does not grant, and it scans again at the edge after that.
- R6: A thread that has been granted is not eligible again until its request has been sampled low at a clock edge. While it keeps its request high, other requesting threads are still served.
- R7: A request whose row is not below ROWS, or whose column is not below COLS, is granted and acknowledged like any other, but no element changes.
- R8: `rdData` equals the element at (`rdRow`, `rdCol`) in the same cycle, and it is zero when either read index is out of range.
- R9: If threads 0 and 1 request at the same edge, thread 0 is acknowledged in the next cycle and thread 1 is acknowledged two cycles after thread 0.
- R10: When no thread is eligible, no acknowledge is raised and the array keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqVec | input | N | Request bit of each thread, bit t for thread t |
| dataFlat | input | N*DATA_W | Write word of each thread, thread t at bits t*DATA_W upward |
| rowFlat | input | N*ROW_W | Row index of each thread, thread t at bits t*ROW_W upward |
| colFlat | input | N*COL_W | Column index of each thread, thread t at bits t*COL_W upward |
| ackVec | output | N | Acknowledge of each thread, bit t for thread t |
| rdRow | input | ROW_W | Read row index |
| rdCol | input | COL_W | Read column index |
| rdData | output | DATA_W | Element at the read indices, zero when out of range |

## Verification
On every cycle the bound checker confirms that at most one acknowledge is high, that each acknowledge lasts one cycle and answers a request sampled at the previous edge, that acknowledges are low after reset, that an out-of-range read returns zero, and that the read data holds steady when no grant happened and the read address did not move. Lowest-number priority, the exclusion of a thread that is slow to release, the timing of the two-thread trace, and the fact that an out-of-range write leaves every element untouched can only be shown by the bench's scenarios. For these, a behavioural reference copy of the array and of the grant sequence is compared with the ports on every clock.

// File: rtl/sharedCoordPkg.sv
package sharedCoordPkg;
  // Width of a thread number carried from control to datapath (up to 16 threads)
  localparam int SEL_W = 4;

  typedef enum logic {
    ST_SCAN = 1'b0,
    ST_WAIT = 1'b1
  } coordState_e;

  // Strobes from the control FSM to the storage datapath
  typedef struct packed {
    logic             wrEn;
    logic [SEL_W-1:0] wrSel;
  } coordStrobe_t;
endpackage

// File: rtl/coordPick.sv
module coordPick
  import sharedCoordPkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]     cand,
  output logic             found,
  output logic [N-1:0]     winOneHot,
  output logic [SEL_W-1:0] winIdx
);
  // Ripple of "some lower-numbered candidate exists"
  logic [N:0] lowerAny;
  assign lowerAny[0] = 1'b0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chain
      assign winOneHot[i]   = cand[i] & ~lowerAny[i];
      assign lowerAny[i+1]  = lowerAny[i] | cand[i];
    end
  endgenerate

  assign found = lowerAny[N];

  always_comb begin
    winIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (winOneHot[i]) winIdx = winIdx | SEL_W'(i);
    end
  end
endmodule

// File: rtl/coordCtrl.sv
module coordCtrl
  import sharedCoordPkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] reqVec,
  output coordStrobe_t strobe,
  output logic [N-1:0] ackVec
);
  coordState_e      state;
  logic [N-1:0]     blockVec;
  logic [N-1:0]     eligible;
  logic [N-1:0]     winOneHot;
  logic [SEL_W-1:0] winIdx;
  logic             found;
  logic             grant;

  // A served thread stays excluded until its request is seen low
  assign eligible = reqVec & ~blockVec;

  coordPick #(.N(N)) u_pick (
    .cand      (eligible),
    .found     (found),
    .winOneHot (winOneHot),
    .winIdx    (winIdx)
  );

  assign grant = (state == ST_SCAN) && found;

  always_comb begin
    strobe.wrEn  = grant;
    strobe.wrSel = winIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_SCAN;
      ackVec   <= '0;
      blockVec <= '0;
    end else begin
      blockVec <= (blockVec & reqVec) | (grant ? winOneHot : '0);
      if (state == ST_WAIT) begin
        state  <= ST_SCAN;
        ackVec <= '0;
      end else if (found) begin
        state  <= ST_WAIT;
        ackVec <= winOneHot;
      end
    end
  end
endmodule

// File: rtl/coordDatapath.sv
module coordDatapath
  import sharedCoordPkg::*;
#(
  parameter int N      = 4,
  parameter int ROWS   = 6,
  parameter int COLS   = 7,
  parameter int DATA_W = 32,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  coordStrobe_t          strobe,
  input  logic [N*DATA_W-1:0]   dataFlat,
  input  logic [N*ROW_W-1:0]    rowFlat,
  input  logic [N*COL_W-1:0]    colFlat,
  input  logic [ROW_W-1:0]      rdRow,
  input  logic [COL_W-1:0]      rdCol,
  output logic [DATA_W-1:0]     rdData
);
  logic [DATA_W-1:0] cells [ROWS][COLS];
  logic [DATA_W-1:0] selData;
  logic [ROW_W-1:0]  selRow;
  logic [COL_W-1:0]  selCol;
  logic              wrInRange;
  logic              rdInRange;

  // Route the granted thread's fields to the write port
  always_comb begin
    selData = '0;
    selRow  = '0;
    selCol  = '0;
    for (int t = 0; t < N; t++) begin
      if (strobe.wrSel == SEL_W'(t)) begin
        selData = dataFlat[t*DATA_W +: DATA_W];
        selRow  = rowFlat[t*ROW_W +: ROW_W];
        selCol  = colFlat[t*COL_W +: COL_W];
      end
    end
  end

  assign wrInRange = ({1'b0, selRow} < (ROW_W+1)'(ROWS)) &&
                     ({1'b0, selCol} < (COL_W+1)'(COLS));
  assign rdInRange = ({1'b0, rdRow} < (ROW_W+1)'(ROWS)) &&
                     ({1'b0, rdCol} < (COL_W+1)'(COLS));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          cells[r][c] <= '0;
        end
      end
    end else if (strobe.wrEn && wrInRange) begin
      cells[selRow][selCol] <= selData;
    end
  end

  assign rdData = rdInRange ? cells[rdRow][rdCol] : '0;
endmodule

// File: rtl/sharedWriteCoord.sv
module sharedWriteCoord
  import sharedCoordPkg::*;
#(
  parameter  int N      = 4,
  parameter  int ROWS   = 6,
  parameter  int COLS   = 7,
  parameter  int DATA_W = 32,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        reqVec,
  input  logic [N*DATA_W-1:0] dataFlat,
  input  logic [N*ROW_W-1:0]  rowFlat,
  input  logic [N*COL_W-1:0]  colFlat,
  output logic [N-1:0]        ackVec,
  input  logic [ROW_W-1:0]    rdRow,
  input  logic [COL_W-1:0]    rdCol,
  output logic [DATA_W-1:0]   rdData
);
  coordStrobe_t strobe;

  coordCtrl #(.N(N)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .reqVec (reqVec),
    .strobe (strobe),
    .ackVec (ackVec)
  );

  coordDatapath #(
    .N(N), .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W),
    .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .dataFlat (dataFlat),
    .rowFlat  (rowFlat),
    .colFlat  (colFlat),
    .rdRow    (rdRow),
    .rdCol    (rdCol),
    .rdData   (rdData)
  );
endmodule

// File: rtl/sharedWriteCoordChk.sv
module sharedWriteCoordChk #(
  parameter  int N      = 4,
  parameter  int ROWS   = 6,
  parameter  int COLS   = 7,
  parameter  int DATA_W = 32,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS)
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      reqVec,
  input logic [N-1:0]      ackVec,
  input logic [ROW_W-1:0]  rdRow,
  input logic [COL_W-1:0]  rdCol,
  input logic [DATA_W-1:0] rdData
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (ackVec == '0));

  assert_ack_answers_req_R2: assert property (@(posedge clk) disable iff (rst)
    ((ackVec != '0) && !$past(rst)) |-> (($past(reqVec) & ackVec) == ackVec));

  assert_ack_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ackVec));

  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (ackVec != '0) |=> (ackVec == '0));

  assert_oob_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (({1'b0, rdRow} >= (ROW_W+1)'(ROWS)) || ({1'b0, rdCol} >= (COL_W+1)'(COLS)))
      |-> (rdData == '0));

  assert_idle_keeps_array_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (ackVec == '0) && $stable(rdRow) && $stable(rdCol))
      |-> $stable(rdData));
endmodule

bind sharedWriteCoord sharedWriteCoordChk #(
  .N(N), .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .reqVec (reqVec),
  .ackVec (ackVec),
  .rdRow  (rdRow),
  .rdCol  (rdCol),
  .rdData (rdData)
);

// File: tb/sharedWriteCoord_tb.sv
`timescale 1ns/1ps
module sharedWriteCoord_tb;
  localparam int N      = 4;
  localparam int ROWS   = 6;
  localparam int COLS   = 7;
  localparam int DATA_W = 32;
  localparam int ROW_W  = $clog2(ROWS);
  localparam int COL_W  = $clog2(COLS);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [N-1:0]        reqVec = '0;
  logic [N*DATA_W-1:0] dataFlat = '0;
  logic [N*ROW_W-1:0]  rowFlat = '0;
  logic [N*COL_W-1:0]  colFlat = '0;
  logic [N-1:0]        ackVec;
  logic [ROW_W-1:0]    rdRow = '0;
  logic [COL_W-1:0]    rdCol = '0;
  logic [DATA_W-1:0]   rdData;

  logic [N-1:0]        hold = '0;
  int                  checks = 0;
  int                  failures = 0;

  always #2 clk = ~clk;

  sharedWriteCoord #(.N(N), .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .reqVec(reqVec), .dataFlat(dataFlat),
    .rowFlat(rowFlat), .colFlat(colFlat), .ackVec(ackVec),
    .rdRow(rdRow), .rdCol(rdCol), .rdData(rdData)
  );

  // Behavioural reference: stored words, expected acks, exclusion bits
  logic [DATA_W-1:0] refArr [ROWS][COLS];
  logic [N-1:0]      refAck = '0;
  logic [N-1:0]      refExcl = '0;
  logic [N-1:0]      newExcl;
  bit                refHoldCycle = 1'b0;
  int                winner;
  int                wr, wc;

  always @(posedge clk) begin
    if (rst) begin
      foreach (refArr[r, c]) refArr[r][c] = '0;
      refAck = '0;
      refExcl = '0;
      refHoldCycle = 1'b0;
    end else begin
      newExcl = refExcl & reqVec;
      if (refHoldCycle) begin
        refAck = '0;
        refHoldCycle = 1'b0;
      end else begin
        winner = -1;
        for (int t = N - 1; t >= 0; t--) begin
          if (reqVec[t] && !refExcl[t]) winner = t;
        end
        if (winner >= 0) begin
          refAck = '0;
          refAck[winner] = 1'b1;
          refHoldCycle = 1'b1;
          newExcl[winner] = 1'b1;
          wr = int'(rowFlat[winner*ROW_W +: ROW_W]);
          wc = int'(colFlat[winner*COL_W +: COL_W]);
          if (wr < ROWS && wc < COLS) refArr[wr][wc] = dataFlat[winner*DATA_W +: DATA_W];
        end
      end
      refExcl = newExcl;
    end
  end

  function automatic logic [DATA_W-1:0] readExpect();
    if (int'(rdRow) < ROWS && int'(rdCol) < COLS) return refArr[rdRow][rdCol];
    return '0;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic post(input int t, input logic [DATA_W-1:0] d,
                      input int r, input int c);
    reqVec[t] = 1'b1;
    dataFlat[t*DATA_W +: DATA_W] = d;
    rowFlat[t*ROW_W +: ROW_W] = ROW_W'(r);
    colFlat[t*COL_W +: COL_W] = COL_W'(c);
  endtask

  // One clock: compare against the reference, then let served threads release
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check(ackVec == refAck, "R2/R5 ack against reference", DATA_W'(ackVec), DATA_W'(refAck));
    check($countones(ackVec) <= 1, "R3 single acknowledge", DATA_W'(ackVec), 0);
    check(rdData == readExpect(), "R8 read port", rdData, readExpect());
    for (int t = 0; t < N; t++) begin
      if (ackVec[t] && !hold[t]) reqVec[t] = 1'b0;
    end
  endtask

  task automatic sweep();
    for (int a = 0; a < (1 << (ROW_W + COL_W)); a++) begin
      rdRow = ROW_W'(a >> COL_W);
      rdCol = COL_W'(a);
      #0.5;
      check(rdData == readExpect(), "R8/R7 array sweep", rdData, readExpect());
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ackVec == '0, "R1 ack low in reset", DATA_W'(ackVec), 0);
    rst = 1'b0;
    step();
    for (int a = 0; a < ROWS * COLS; a++) begin
      rdRow = ROW_W'(a / COLS);
      rdCol = COL_W'(a % COLS);
      #0.2;
      check(rdData == '0, "R1 element cleared", rdData, 0);
    end

    // R10: idle cycles raise nothing
    for (int k = 0; k < 4; k++) begin
      step();
      check(ackVec == '0, "R10 no request no ack", DATA_W'(ackVec), 0);
    end

    // R9 / R4: two threads request together
    rdRow = 1; rdCol = 2;
    post(0, 32'd22, 1, 2);
    post(1, 32'd44, 5, 6);
    step();
    check(ackVec == 4'b0001, "R4 thread 0 served first", DATA_W'(ackVec), 1);
    check(rdData == 32'd22, "R2 element written", rdData, 22);
    step();
    check(ackVec == 4'b0000, "R5 ack one cycle", DATA_W'(ackVec), 0);
    rdRow = 5; rdCol = 6;
    step();
    check(ackVec == 4'b0010, "R9 thread 1 two cycles later", DATA_W'(ackVec), 2);
    check(rdData == 32'd44, "R9 second element written", rdData, 44);
    step();

    // R6: thread 2 keeps its request high after being served
    hold[2] = 1'b1;
    post(2, 32'h7, 0, 0);
    post(3, 32'h9, 0, 1);
    step();
    check(ackVec == 4'b0100, "R6 thread 2 granted", DATA_W'(ackVec), 4);
    step();
    step();
    check(ackVec == 4'b1000, "R6 other thread served meanwhile", DATA_W'(ackVec), 8);
    step();
    step();
    check(ackVec == 4'b0000, "R6 holder not regranted", DATA_W'(ackVec), 0);
    reqVec[2] = 1'b0;
    step();
    post(2, 32'h11, 0, 0);
    step();
    check(ackVec == 4'b0100, "R6 regranted after release", DATA_W'(ackVec), 4);
    hold[2] = 1'b0;
    reqVec[2] = 1'b0;
    step();

    // R7: out-of-range indices acknowledged, nothing stored
    post(1, 32'hDEAD_BEEF, 6, 3);
    step();
    check(ackVec == 4'b0010, "R7 out-of-range row acknowledged", DATA_W'(ackVec), 2);
    step();
    post(3, 32'hCAFE_F00D, 2, 7);
    step();
    check(ackVec == 4'b1000, "R7 out-of-range column acknowledged", DATA_W'(ackVec), 8);
    step();
    step();
    sweep();

    // Mixed traffic, all threads releasing after their acknowledge
    for (int k = 0; k < 3000; k++) begin
      for (int t = 0; t < N; t++) begin
        if (!reqVec[t] && ($urandom % 10) < 3)
          post(t, $urandom, int'($urandom % 8), int'($urandom % 8));
      end
      rdRow = ROW_W'($urandom);
      rdCol = COL_W'($urandom);
      step();
    end
    reqVec = '0;
    step();
    step();
    sweep();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule